// File: doc/BRIEF.md
# Serial Audio Multi-Tap Delay Aligner

This block takes one serial audio stream (bit clock, word select and serial data) and feeds four serial DAC inputs. All four come from taps of one shared shift register. Word select and data enter the register together on every rising bit-clock edge. Each tap delays the stream by its own whole number of bit periods. The DACs can therefore be wired to different data offsets, for example to pick out different words in a frame, and still latch their samples on the same edge.

Every output is taken from a registered tap and never from the raw input. All DACs share one bit clock, which is the input bit clock inverted. The DACs therefore sample half a bit period after the taps have changed, so no DAC sampling edge lands on a tap transition. The register is as long as the largest tap. The tap positions are compile-time parameters.

Top module: `serial_tap_aligner`

## Requirements
- R1: Output k is the input delayed by TAP_DLY[k] rising `bck` edges. The defaults are 1, 33, 17 and 25 for bus bits 0, 1, 2 and 3. A value sampled at one rising edge appears on output k right after the (TAP_DLY[k]-1)-th rising edge that follows that edge. It then stays for exactly one bit period.
- R2: `dac_bck_n` is always the logical inverse of `bck`.
- R3: Each `dac_ws` bit is delayed by exactly the same number of edges as the `dac_data` bit of the same index, so word boundaries stay aligned with their data.
- R4: The tap outputs change only just after a rising `bck` edge. They hold their value through the falling `bck` edge, which is the rising edge of `dac_bck_n`, where the DACs sample.
- R5: `rst_n` is active low and synchronous. Any rising `bck` edge with `rst_n` low clears every stage, so all outputs read 0. Lowering `rst_n` between edges leaves the outputs unchanged until the next rising edge.
- R6: No output follows the undelayed input. A change on `sdata_in` or `ws_in` while `bck` is low leaves every output unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bck | input | 1 | Serial bit clock; the shift register advances on its rising edge |
| rst_n | input | 1 | Active-low synchronous clear of every stage |
| sdata_in | input | 1 | Serial audio data in |
| ws_in | input | 1 | Word select in |
| dac_data | output | NUM_TAPS | Delayed data, one bit per DAC |
| dac_ws | output | NUM_TAPS | Delayed word select, one bit per DAC |
| dac_bck_n | output | 1 | Inverted bit clock shared by all DACs |

## Verification
The tests use several input patterns, and each one exposes a different kind of error:
- A single one-bit pulse on data with word select held low. This gives each tap's delay as one exact edge count and catches off-by-one tap selection.
- A pseudo-random data stream with word select toggling every 16 bits. This shows that the two lanes stay in lockstep, and that no tap is wired to the wrong lane or swapped with another tap.
- Input flips while the clock is low, and samples taken on both sides of the falling edge. These separate a registered tap from a combinational leak of the input, and confirm that the outputs hold across the DAC sampling edge.
- A reset dropped in mid-stream. This tells a synchronous clear from an asynchronous one.

// File: rtl/tap_align_pkg.sv
package tap_align_pkg;

    // Default number of DAC feeds taken from the shared register
    localparam int unsigned DEF_NUM_TAPS = 4;

    // One serial lane pair: data bit and word select travel together
    typedef struct packed {
        logic data;
        logic ws;
    } serial_pair_t;

endpackage

// File: rtl/tap_shift_chain.sv
module tap_shift_chain
    import tap_align_pkg::*;
#(
    parameter int unsigned DEPTH = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  serial_pair_t     pair_in,
    output logic [DEPTH-1:0] data_stages,
    output logic [DEPTH-1:0] ws_stages
);

    typedef struct packed {
        logic [DEPTH-1:0] data;
        logic [DEPTH-1:0] ws;
    } chain_t;

    chain_t chain_d;
    chain_t chain_q;

    // Next state: both lanes move one stage per rising edge
    always_comb begin
        chain_d = chain_q;
        if (!rst_n) begin
            chain_d = '0;
        end else begin
            chain_d.data = (chain_q.data << 1) | DEPTH'(pair_in.data);
            chain_d.ws   = (chain_q.ws   << 1) | DEPTH'(pair_in.ws);
        end
    end

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign data_stages = chain_q.data;
    assign ws_stages   = chain_q.ws;

    // Both lanes enter together: equal inputs give equal first stages
    AST_PAIR_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(pair_in.data) == $past(pair_in.ws)))
            |-> (chain_q.data[0] == chain_q.ws[0])); // R3

endmodule

// File: rtl/tap_picker.sv
module tap_picker #(
    parameter int unsigned NUM_TAPS          = 4,
    parameter int unsigned DEPTH             = 33,
    parameter int unsigned TAP_DLY[NUM_TAPS] = '{1, 33, 17, 25}
) (
    input  logic [DEPTH-1:0]    data_stages,
    input  logic [DEPTH-1:0]    ws_stages,
    output logic [NUM_TAPS-1:0] tap_data,
    output logic [NUM_TAPS-1:0] tap_ws
);

    // A delay of N edges is read from stage N-1; stage 0 is already one edge late
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int unsigned STAGE = TAP_DLY[g] - 1;
        assign tap_data[g] = data_stages[STAGE];
        assign tap_ws[g]   = ws_stages[STAGE];
    end

endmodule

// File: rtl/bck_inverter.sv
module bck_inverter (
    input  logic bck,
    output logic bck_n
);

    // DAC sampling edge sits half a bit period after the register update
    assign bck_n = ~bck;

endmodule

// File: rtl/serial_tap_aligner.sv
module serial_tap_aligner
    import tap_align_pkg::*;
#(
    parameter int unsigned NUM_TAPS          = DEF_NUM_TAPS,
    parameter int unsigned TAP_DLY[NUM_TAPS] = '{1, 33, 17, 25}
) (
    input  logic                bck,
    input  logic                rst_n,
    input  logic                sdata_in,
    input  logic                ws_in,
    output logic [NUM_TAPS-1:0] dac_data,
    output logic [NUM_TAPS-1:0] dac_ws,
    output logic                dac_bck_n
);

    function automatic int unsigned longest_tap();
        int unsigned m = 1;
        for (int i = 0; i < NUM_TAPS; i++) begin
            if (TAP_DLY[i] > m) m = TAP_DLY[i];
        end
        return m;
    endfunction

    // Register length follows the largest requested delay
    localparam int unsigned DEPTH = longest_tap();

    serial_pair_t     pair_in;
    logic [DEPTH-1:0] data_stages;
    logic [DEPTH-1:0] ws_stages;

    assign pair_in.data = sdata_in;
    assign pair_in.ws   = ws_in;

    tap_shift_chain #(
        .DEPTH (DEPTH)
    ) u_chain (
        .clk         (bck),
        .rst_n       (rst_n),
        .pair_in     (pair_in),
        .data_stages (data_stages),
        .ws_stages   (ws_stages)
    );

    tap_picker #(
        .NUM_TAPS (NUM_TAPS),
        .DEPTH    (DEPTH),
        .TAP_DLY  (TAP_DLY)
    ) u_pick (
        .data_stages (data_stages),
        .ws_stages   (ws_stages),
        .tap_data    (dac_data),
        .tap_ws      (dac_ws)
    );

    bck_inverter u_inv (
        .bck   (bck),
        .bck_n (dac_bck_n)
    );

    // Any edge taken in reset leaves every feed at zero
    AST_RESET_CLEARS: assert property (@(posedge bck)
        !rst_n |=> ((dac_data == '0) && (dac_ws == '0))); // R5

    // Right before each register update the DAC clock is high, so its rising edge is elsewhere
    AST_DAC_EDGE_SPLIT: assert property (@(posedge bck) disable iff (!rst_n)
        dac_bck_n == 1'b1); // R2

    // Feeds with a one-edge delay follow the previous input sample
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_chk
        if (TAP_DLY[g] == 1) begin : g_one
            AST_SINGLE_EDGE_TAP: assert property (@(posedge bck) disable iff (!rst_n)
                $past(rst_n) |-> ((dac_data[g] == $past(sdata_in))
                               && (dac_ws[g] == $past(ws_in)))); // R1
        end
    end

endmodule

// File: tb/sim_serial_tap_aligner.sv
module sim_serial_tap_aligner;

    localparam int NT = 4;
    localparam int unsigned TAPS[NT] = '{1, 33, 17, 25};

    logic bck      = 1'b0;
    logic rst_n    = 1'b0;
    logic sdata_in = 1'b0;
    logic ws_in    = 1'b0;
    logic [NT-1:0] dac_data;
    logic [NT-1:0] dac_ws;
    logic          dac_bck_n;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference history: bit i is the input sampled i+1 edges ago
    logic [63:0] ref_d = '0;
    logic [63:0] ref_w = '0;

    serial_tap_aligner #(.NUM_TAPS(NT), .TAP_DLY(TAPS)) u0 (
        .bck       (bck),
        .rst_n     (rst_n),
        .sdata_in  (sdata_in),
        .ws_in     (ws_in),
        .dac_data  (dac_data),
        .dac_ws    (dac_ws),
        .dac_bck_n (dac_bck_n)
    );

    always #5 bck = ~bck;

    always @(posedge bck) begin
        if (!rst_n) begin
            ref_d <= '0;
            ref_w <= '0;
        end else begin
            ref_d <= {ref_d[62:0], sdata_in};
            ref_w <= {ref_w[62:0], ws_in};
        end
    end

    function automatic logic [NT-1:0] exp_data();
        logic [NT-1:0] e;
        for (int k = 0; k < NT; k++) e[k] = ref_d[TAPS[k]-1];
        return e;
    endfunction

    function automatic logic [NT-1:0] exp_ws();
        logic [NT-1:0] e;
        for (int k = 0; k < NT; k++) e[k] = ref_w[TAPS[k]-1];
        return e;
    endfunction

    task automatic cmp(string req, string what, logic [NT-1:0] act, logic [NT-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cmp_model(string req);
        cmp(req, "data", dac_data, exp_data());
        cmp(req, "ws", dac_ws, exp_ws());
    endtask

    // Check at the falling edge, then present the next input bit
    task automatic step(string req, logic d, logic w);
        @(negedge bck);
        cmp_model(req);
        sdata_in = d;
        ws_in    = w;
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        sdata_in = 1'b1;
        ws_in = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge bck);
            cmp("R5", "data", dac_data, '0);
            cmp("R5", "ws", dac_ws, '0);
        end
        #1;
        cmp("R2", "bck_n_low_phase", {3'b0, dac_bck_n}, {3'b0, ~bck});
        @(posedge bck);
        #1;
        cmp("R2", "bck_n_high_phase", {3'b0, dac_bck_n}, {3'b0, ~bck});
        @(negedge bck);
        sdata_in = 1'b0;
        ws_in = 1'b0;
        rst_n = 1'b1;
    endtask

    // R1: one pulse must show up once per feed, exactly at its tap count
    task automatic t_single_pulse();
        int seen[NT];
        for (int k = 0; k < NT; k++) seen[k] = 0;
        step("R1", 1'b1, 1'b0);
        for (int i = 0; i < 40; i++) begin
            step("R1", 1'b0, 1'b0);
            for (int k = 0; k < NT; k++) if (dac_data[k]) seen[k]++;
        end
        for (int k = 0; k < NT; k++) begin
            n_cmp++;
            if (seen[k] != 1) begin
                n_bad++;
                $display("FAIL R1 pulse_count tap%0d actual=%0d expected=1", k, seen[k]);
            end
        end
    endtask

    // R1 R3: random data with framed word select
    task automatic t_frames();
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < 140; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step("R3", lfsr[0], (i / 16) % 2 == 1);
        end
    endtask

    // R6: input changes while bck is low must not reach any feed
    task automatic t_no_raw_path();
        for (int i = 0; i < 6; i++) begin
            logic [NT-1:0] hd;
            logic [NT-1:0] hw;
            @(negedge bck);
            #1;
            hd = dac_data;
            hw = dac_ws;
            sdata_in = ~sdata_in;
            ws_in = (i % 2 == 0);
            #2;
            cmp("R6", "data", dac_data, hd);
            cmp("R6", "ws", dac_ws, hw);
        end
    endtask

    // R4 R2: feeds hold across the DAC sampling edge
    task automatic t_half_period();
        for (int i = 0; i < 8; i++) begin
            logic [NT-1:0] hd;
            logic [NT-1:0] hw;
            @(posedge bck);
            #1;
            hd = dac_data;
            hw = dac_ws;
            cmp("R2", "bck_n_high", {3'b0, dac_bck_n}, 4'b0000);
            @(negedge bck);
            #1;
            cmp("R4", "data", dac_data, hd);
            cmp("R4", "ws", dac_ws, hw);
            cmp("R2", "bck_n_low", {3'b0, dac_bck_n}, 4'b0001);
            sdata_in = (i % 3 == 0);
            ws_in = (i % 2 == 0);
        end
    endtask

    // R5: reset takes effect only on the next rising edge
    task automatic t_sync_reset();
        for (int i = 0; i < 40; i++) step("R1", 1'b1, 1'b1);
        @(negedge bck);
        cmp_model("R5");
        rst_n = 1'b0;
        #1;
        cmp("R5", "data_before_edge", dac_data, 4'b1111);
        cmp("R5", "ws_before_edge", dac_ws, 4'b1111);
        @(negedge bck);
        cmp("R5", "data_after_edge", dac_data, '0);
        cmp("R5", "ws_after_edge", dac_ws, '0);
        rst_n = 1'b1;
        for (int i = 0; i < 36; i++) step("R5", 1'b1, 1'b0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        t_reset_state();
        t_single_pulse();
        t_frames();
        t_no_raw_path();
        t_half_period();
        t_sync_reset();
        finish_run();
    end

    initial begin
        #2000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule